// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block keeps the reservations that pair a load-exclusive with its later store-exclusive, for a small set of processors. A load-exclusive posts a mark carrying a physical address, an access size, the requesting processor's id and a shareable flag. Each processor owns one local reservation slot. Marks to shareable memory also fill that processor's entry in a global table, which tracks reservations other agents can disturb.

A store-exclusive posts a check request. The block decides pass or fail, or raises an alignment fault when the address is misaligned for its size. The result is registered and comes back one cycle later. A passing check drops the requester's local reservation. Software-level clears use a per-processor clear-local vector. Ordinary stores to shareable memory are fed to a clear-by-address port, and any global entry whose byte range overlaps the store is removed.

Top module: `excl_monitor`

## Requirements
- R1: After reset no processor holds a local or global reservation, the three result outputs are low, and a check with no prior mark fails.
- R2: A mark with the shareable flag low fills only the requester's local slot. A later matching non-shareable check passes, and a later matching shareable check fails.
- R3: A mark with the shareable flag high fills both the requester's local slot and its global entry, so a later matching shareable check passes.
- R4: A shareable check passes only when both the local and the global lookups succeed. A non-shareable check uses the local lookup alone and ignores the global table.
- R5: A lookup succeeds only when the processor's entry is valid and holds exactly the requested address and size code.
- R6: A passing check invalidates the requester's local slot, so an identical second check fails. A failing check leaves the slot as it was.
- R7: A check whose address is not a multiple of its byte count raises fault, forces pass low and changes no reservation.
- R8: Bit p of the clear-local vector invalidates processor p's local slot only. Other processors keep theirs.
- R9: A store with the shareable flag high invalidates every global entry whose byte range overlaps the store's byte range. Non-overlapping stores and stores with the shareable flag low change nothing.
- R10: For each check, done, pass and fault are valid in the cycle after the request. Done is low in every other cycle.
- R11: Within one cycle a check is judged against the state before that cycle's updates. A mark for a processor takes priority over a clear-local or pass-clear of the same processor in the same cycle.
- R12: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An entry with base a and code s covers bytes a through a+2^s-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_vld | input | 1 | Mark request strobe |
| mark_addr | input | AW | Mark physical address |
| mark_szl | input | 2 | Mark size code (log2 bytes) |
| mark_pid | input | PW | Marking processor |
| mark_shr | input | 1 | Mark targets shareable memory |
| chk_vld | input | 1 | Check request strobe |
| chk_addr | input | AW | Check physical address |
| chk_szl | input | 2 | Check size code |
| chk_pid | input | PW | Checking processor |
| chk_shr | input | 1 | Check targets shareable memory |
| clr_loc | input | NPROC | Per-processor local clear |
| st_vld | input | 1 | Ordinary store strobe |
| st_addr | input | AW | Store address |
| st_szl | input | 2 | Store size code |
| st_shr | input | 1 | Store targets shareable memory |
| res_done | output | 1 | Check result valid |
| res_pass | output | 1 | Store-exclusive may proceed |
| res_fault | output | 1 | Alignment fault on check |

## Verification
Reservation updates from marks, clears and stores take effect at the clock edge that samples them. Check results appear on the outputs one edge after the request. The bench drives every request at a falling edge and drops it at the next falling edge, where it samples done, pass and fault, which by then hold the response to that request. In every cycle without a check it expects done to be low. Same-cycle interactions are driven together in one cycle, and the next check is read one cycle later.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef logic [1:0] szl_t;

  // one past the last byte covered by (base, size code)
  function automatic logic [64:0] span_end(input logic [63:0] base, input szl_t szl);
    return {1'b0, base} + (65'd1 << szl);
  endfunction

  function automatic logic size_aligned(input logic [63:0] a, input szl_t szl);
    logic [63:0] mask;
    mask = (64'd1 << szl) - 64'd1;
    return (a & mask) == 64'd0;
  endfunction

  function automatic logic bytes_overlap(input logic [63:0] a, input szl_t sa,
                                         input logic [63:0] b, input szl_t sb);
    return ({1'b0, a} < span_end(b, sb)) && ({1'b0, b} < span_end(a, sa));
  endfunction

endpackage

// File: rtl/excl_mon_local_slot.sv
module excl_mon_local_slot
  import excl_mon_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  szl_t          set_szl,
  input  logic          drop_en,
  output logic          slot_vld,
  output logic [AW-1:0] slot_addr,
  output szl_t          slot_szl
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld  <= 1'b0;
      slot_addr <= '0;
      slot_szl  <= '0;
    end else if (set_en) begin
      slot_vld  <= 1'b1;
      slot_addr <= set_addr;
      slot_szl  <= set_szl;
    end else if (drop_en) begin
      slot_vld  <= 1'b0;
    end
  end

  // R11: a mark outranks a same-cycle drop
  a_r11_mark_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (slot_vld && slot_addr == $past(set_addr)));

  // R8 / R6: a drop without a mark empties the slot
  a_r8_drop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_en && !set_en) |=> !slot_vld);

  // R7: without set or drop the slot holds
  a_r7_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!drop_en && !set_en) |=> ($stable(slot_vld) && $stable(slot_addr) && $stable(slot_szl)));

endmodule

// File: rtl/excl_mon_global_tbl.sv
module excl_mon_global_tbl
  import excl_mon_pkg::*;
#(
  parameter int unsigned NPROC = 4,
  parameter int unsigned AW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPROC-1:0]          set_en,
  input  logic [AW-1:0]             set_addr,
  input  szl_t                      set_szl,
  input  logic                      st_vld,
  input  logic                      st_shr,
  input  logic [AW-1:0]             st_addr,
  input  szl_t                      st_szl,
  output logic [NPROC-1:0]          g_vld,
  output logic [NPROC-1:0][AW-1:0]  g_addr,
  output szl_t [NPROC-1:0]          g_szl
);

  logic             st_live;
  logic [NPROC-1:0] kill;

  assign st_live = st_vld && st_shr;

  for (genvar p = 0; p < NPROC; p++) begin : g_ent
    assign kill[p] = st_live && g_vld[p] &&
                     bytes_overlap(64'(g_addr[p]), g_szl[p], 64'(st_addr), st_szl);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        g_vld[p]  <= 1'b0;
        g_addr[p] <= '0;
        g_szl[p]  <= '0;
      end else if (set_en[p]) begin
        g_vld[p]  <= 1'b1;
        g_addr[p] <= set_addr;
        g_szl[p]  <= set_szl;
      end else if (kill[p]) begin
        g_vld[p]  <= 1'b0;
      end
    end

    // R9: an overlapping shareable store removes the entry
    a_r9_store_kills: assert property (@(posedge clk) disable iff (!rst_n)
      (kill[p] && !set_en[p]) |=> !g_vld[p]);

    // R2 / R9: no shareable mark and no overlap leaves the entry alone
    a_r2_entry_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en[p] && !kill[p]) |=> ($stable(g_vld[p]) && $stable(g_addr[p])));

    // R3: a shareable mark fills the entry
    a_r3_mark_fills: assert property (@(posedge clk) disable iff (!rst_n)
      set_en[p] |=> g_vld[p]);
  end

endmodule

// File: rtl/excl_mon_check.sv
module excl_mon_check
  import excl_mon_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [AW-1:0] req_addr,
  input  szl_t          req_szl,
  input  logic          req_shr,
  input  logic          loc_vld,
  input  logic [AW-1:0] loc_addr,
  input  szl_t          loc_szl,
  input  logic          glb_vld,
  input  logic [AW-1:0] glb_addr,
  input  szl_t          glb_szl,
  output logic          pass_evt,
  output logic          fault_evt,
  output logic          res_done,
  output logic          res_pass,
  output logic          res_fault
);

  logic aligned;
  logic loc_ok;
  logic glb_ok;
  logic verdict;

  assign aligned   = size_aligned(64'(req_addr), req_szl);
  assign loc_ok    = loc_vld && (loc_addr == req_addr) && (loc_szl == req_szl);
  assign glb_ok    = glb_vld && (glb_addr == req_addr) && (glb_szl == req_szl);
  assign verdict   = loc_ok && (!req_shr || glb_ok);
  assign pass_evt  = req_vld && aligned && verdict;
  assign fault_evt = req_vld && !aligned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_done  <= 1'b0;
      res_pass  <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_done  <= req_vld;
      res_pass  <= pass_evt;
      res_fault <= fault_evt;
    end
  end

  // R10: result one cycle after the request, nothing otherwise
  a_r10_done_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_done);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!res_done && !res_pass && !res_fault));

  // R7: misaligned request faults and never passes
  a_r7_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !aligned) |=> (res_fault && !res_pass));

  // R4: shareable request without global match fails
  a_r4_need_global: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_shr && !glb_ok) |=> !res_pass);

  // R5: no local match, no pass
  a_r5_need_local: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !loc_ok) |=> !res_pass);

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int unsigned NPROC = 4,
  parameter int unsigned AW    = 32,
  localparam int unsigned PW   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_vld,
  input  logic [AW-1:0]    mark_addr,
  input  logic [1:0]       mark_szl,
  input  logic [PW-1:0]    mark_pid,
  input  logic             mark_shr,
  input  logic             chk_vld,
  input  logic [AW-1:0]    chk_addr,
  input  logic [1:0]       chk_szl,
  input  logic [PW-1:0]    chk_pid,
  input  logic             chk_shr,
  input  logic [NPROC-1:0] clr_loc,
  input  logic             st_vld,
  input  logic [AW-1:0]    st_addr,
  input  logic [1:0]       st_szl,
  input  logic             st_shr,
  output logic             res_done,
  output logic             res_pass,
  output logic             res_fault
);

  logic [NPROC-1:0]         mark_hit;
  logic [NPROC-1:0]         glb_set;
  logic [NPROC-1:0]         pass_drop;
  logic [NPROC-1:0]         loc_drop;
  logic [NPROC-1:0]         loc_vld_v;
  logic [NPROC-1:0][AW-1:0] loc_addr_v;
  szl_t [NPROC-1:0]         loc_szl_v;
  logic [NPROC-1:0]         g_vld;
  logic [NPROC-1:0][AW-1:0] g_addr;
  szl_t [NPROC-1:0]         g_szl;
  logic                     pass_evt;
  logic                     fault_evt;

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    assign mark_hit[p]  = mark_vld && (mark_pid == PW'(p));
    assign glb_set[p]   = mark_hit[p] && mark_shr;
    assign pass_drop[p] = pass_evt && (chk_pid == PW'(p));
    assign loc_drop[p]  = clr_loc[p] || pass_drop[p];

    excl_mon_local_slot #(.AW(AW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (mark_hit[p]),
      .set_addr (mark_addr),
      .set_szl  (mark_szl),
      .drop_en  (loc_drop[p]),
      .slot_vld (loc_vld_v[p]),
      .slot_addr(loc_addr_v[p]),
      .slot_szl (loc_szl_v[p])
    );
  end

  excl_mon_global_tbl #(.NPROC(NPROC), .AW(AW)) u_gtbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (glb_set),
    .set_addr(mark_addr),
    .set_szl (mark_szl),
    .st_vld  (st_vld),
    .st_shr  (st_shr),
    .st_addr (st_addr),
    .st_szl  (st_szl),
    .g_vld   (g_vld),
    .g_addr  (g_addr),
    .g_szl   (g_szl)
  );

  excl_mon_check #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (chk_vld),
    .req_addr (chk_addr),
    .req_szl  (chk_szl),
    .req_shr  (chk_shr),
    .loc_vld  (loc_vld_v[chk_pid]),
    .loc_addr (loc_addr_v[chk_pid]),
    .loc_szl  (loc_szl_v[chk_pid]),
    .glb_vld  (g_vld[chk_pid]),
    .glb_addr (g_addr[chk_pid]),
    .glb_szl  (g_szl[chk_pid]),
    .pass_evt (pass_evt),
    .fault_evt(fault_evt),
    .res_done (res_done),
    .res_pass (res_pass),
    .res_fault(res_fault)
  );

  // R6: a pass clears at most the requester's slot
  a_r6_one_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pass_drop));

  // R7: a faulting check clears nothing
  a_r7_fault_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> (pass_drop == '0));

  // R6: after a pass without a new mark the requester's slot is empty
  a_r6_pass_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_evt && !mark_hit[chk_pid]) |=> !loc_vld_v[$past(chk_pid)]);

  // R1: nothing reserved straight after reset
  a_r1_reset_clean: assert property (@(posedge clk)
    !rst_n |=> (loc_vld_v == '0 && g_vld == '0 && !res_done));

endmodule

// File: tb/excl_monitor_tb_top.sv
`timescale 1ns/1ps
module excl_monitor_tb_top;

  localparam int unsigned NPROC = 4;
  localparam int unsigned AW    = 32;
  localparam int unsigned PW    = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic mark_vld, chk_vld, st_vld;
  logic [AW-1:0] mark_addr, chk_addr, st_addr;
  logic [1:0] mark_szl, chk_szl, st_szl;
  logic [PW-1:0] mark_pid, chk_pid;
  logic mark_shr, chk_shr, st_shr;
  logic [NPROC-1:0] clr_loc;
  logic res_done, res_pass, res_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  excl_monitor #(.NPROC(NPROC), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .mark_vld(mark_vld), .mark_addr(mark_addr), .mark_szl(mark_szl),
    .mark_pid(mark_pid), .mark_shr(mark_shr),
    .chk_vld(chk_vld), .chk_addr(chk_addr), .chk_szl(chk_szl),
    .chk_pid(chk_pid), .chk_shr(chk_shr),
    .clr_loc(clr_loc),
    .st_vld(st_vld), .st_addr(st_addr), .st_szl(st_szl), .st_shr(st_shr),
    .res_done(res_done), .res_pass(res_pass), .res_fault(res_fault)
  );

  // vector: {op[1:0], pid[1:0], shr, szl[1:0], addr[15:0], exp_pass, exp_fault}
  // op 0 mark, 1 check, 2 clear-local, 3 store
  localparam int NV = 23;
  localparam logic [24:0] VECS [0:NV-1] = '{
    {2'd0, 2'd0, 1'b0, 2'd2, 16'h0100, 1'b0, 1'b0}, // R2 mark local only
    {2'd1, 2'd0, 1'b1, 2'd2, 16'h0100, 1'b0, 1'b0}, // R2 R4 shareable check fails
    {2'd1, 2'd0, 1'b0, 2'd2, 16'h0100, 1'b1, 1'b0}, // R2 non-shareable passes
    {2'd1, 2'd0, 1'b0, 2'd2, 16'h0100, 1'b0, 1'b0}, // R6 second check fails
    {2'd0, 2'd1, 1'b1, 2'd3, 16'h0200, 1'b0, 1'b0}, // R3 shareable mark
    {2'd1, 2'd1, 1'b1, 2'd2, 16'h0200, 1'b0, 1'b0}, // R5 size mismatch
    {2'd1, 2'd1, 1'b1, 2'd3, 16'h0208, 1'b0, 1'b0}, // R5 address mismatch
    {2'd1, 2'd1, 1'b1, 2'd3, 16'h0201, 1'b0, 1'b1}, // R7 misaligned
    {2'd1, 2'd1, 1'b1, 2'd3, 16'h0204, 1'b0, 1'b1}, // R7 R12 4 not multiple of 8
    {2'd1, 2'd1, 1'b1, 2'd3, 16'h0200, 1'b1, 1'b0}, // R3 R7 state kept
    {2'd0, 2'd2, 1'b1, 2'd2, 16'h0300, 1'b0, 1'b0},
    {2'd0, 2'd3, 1'b1, 2'd2, 16'h0300, 1'b0, 1'b0},
    {2'd2, 2'd2, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0}, // R8 clear p2
    {2'd1, 2'd3, 1'b1, 2'd2, 16'h0300, 1'b1, 1'b0}, // R8 p3 kept
    {2'd1, 2'd2, 1'b1, 2'd2, 16'h0300, 1'b0, 1'b0}, // R8 p2 gone
    {2'd0, 2'd2, 1'b1, 2'd1, 16'h0400, 1'b0, 1'b0},
    {2'd3, 2'd0, 1'b0, 2'd2, 16'h0400, 1'b0, 1'b0}, // R9 non-shareable store
    {2'd3, 2'd0, 1'b1, 2'd0, 16'h0402, 1'b0, 1'b0}, // R9 R12 adjacent byte
    {2'd1, 2'd2, 1'b1, 2'd1, 16'h0400, 1'b1, 1'b0}, // R9 entry survived
    {2'd0, 2'd0, 1'b1, 2'd2, 16'h0500, 1'b0, 1'b0},
    {2'd3, 2'd0, 1'b1, 2'd0, 16'h0503, 1'b0, 1'b0}, // R9 R12 last byte overlap
    {2'd1, 2'd0, 1'b1, 2'd2, 16'h0500, 1'b0, 1'b0}, // R9 global removed
    {2'd1, 2'd0, 1'b0, 2'd2, 16'h0500, 1'b1, 1'b0}  // R4 local alone suffices
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mark_vld = 0; chk_vld = 0; st_vld = 0; clr_loc = '0;
    mark_addr = '0; chk_addr = '0; st_addr = '0;
    mark_szl = '0; chk_szl = '0; st_szl = '0;
    mark_pid = '0; chk_pid = '0; mark_shr = 0; chk_shr = 0; st_shr = 0;
  endtask

  task automatic expect_result(input bit done, input bit pass, input bit fault, input string req);
    check(res_done == done, {req, " done"}, int'(res_done), int'(done));
    check(res_pass == pass, {req, " pass"}, int'(res_pass), int'(pass));
    check(res_fault == fault, {req, " fault"}, int'(res_fault), int'(fault));
  endtask

  task automatic do_check(input int pid, input bit shr, input int szl, input int addr,
                          input bit ep, input bit ef, input string req);
    @(negedge clk);
    chk_vld = 1; chk_pid = PW'(pid); chk_shr = shr; chk_szl = 2'(szl); chk_addr = AW'(addr);
    @(negedge clk);
    idle_inputs();
    expect_result(1'b1, ep, ef, req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    expect_result(1'b0, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1;
    do_check(0, 1'b0, 0, 0, 1'b0, 1'b0, "R1 empty after reset");
    @(negedge clk);
    expect_result(1'b0, 1'b0, 1'b0, "R10 idle cycle");

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VECS[i];
      @(negedge clk);
      case (v[24:23])
        2'd0: begin mark_vld = 1; mark_pid = v[22:21]; mark_shr = v[20];
                    mark_szl = v[19:18]; mark_addr = AW'(v[17:2]); end
        2'd1: begin chk_vld = 1; chk_pid = v[22:21]; chk_shr = v[20];
                    chk_szl = v[19:18]; chk_addr = AW'(v[17:2]); end
        2'd2: clr_loc[v[22:21]] = 1'b1;
        default: begin st_vld = 1; st_shr = v[20]; st_szl = v[19:18];
                       st_addr = AW'(v[17:2]); end
      endcase
      @(negedge clk);
      idle_inputs();
      if (v[24:23] == 2'd1)
        expect_result(1'b1, v[1], v[0], $sformatf("R4 vec%0d", i));
      else
        expect_result(1'b0, 1'b0, 1'b0, $sformatf("R10 vec%0d", i));
    end

    // R11: mark, clear-local and check on p1 in one cycle
    @(negedge clk);
    mark_vld = 1; mark_pid = 2'd1; mark_shr = 0; mark_szl = 2'd2; mark_addr = 32'h600;
    clr_loc = 4'b0010;
    chk_vld = 1; chk_pid = 2'd1; chk_shr = 0; chk_szl = 2'd2; chk_addr = 32'h600;
    @(negedge clk);
    idle_inputs();
    expect_result(1'b1, 1'b0, 1'b0, "R11 old state judged");
    do_check(1, 1'b0, 2, 32'h600, 1'b1, 1'b0, "R11 mark won");

    // R8: multi-bit clear leaves p3 untouched
    @(negedge clk);
    mark_vld = 1; mark_pid = 2'd3; mark_shr = 1; mark_szl = 2'd0; mark_addr = 32'h7ff;
    @(negedge clk);
    idle_inputs(); mark_vld = 1; mark_pid = 2'd0; mark_szl = 2'd0; mark_addr = 32'h10;
    @(negedge clk);
    idle_inputs(); clr_loc = 4'b0111;
    @(negedge clk);
    idle_inputs();
    do_check(0, 1'b0, 0, 32'h10, 1'b0, 1'b0, "R8 p0 cleared");
    do_check(3, 1'b1, 0, 32'h7ff, 1'b1, 1'b0, "R8 p3 kept, R12 byte size");

    // R1: reset drops a live reservation
    @(negedge clk);
    mark_vld = 1; mark_pid = 2'd2; mark_shr = 0; mark_szl = 2'd1; mark_addr = 32'h20;
    @(negedge clk);
    idle_inputs(); rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    do_check(2, 1'b0, 1, 32'h20, 1'b0, 1'b0, "R1 reset clears");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule